// File: doc/BRIEF.md
# Shared-Bus Accumulator Datapath

This block holds the registers and the ALU of a small 16-bit accumulator machine. An external sequencer presents one 19-bit control word per clock. The word picks what drives the two ALU operand buses, which ALU function runs, whether memory is read or written, and which registers capture the single result bus at the next rising edge.

The block keeps five registers:

- a 16-bit accumulator;
- a 16-bit memory buffer;
- an 11-bit program counter;
- an 11-bit memory address register;
- a 5-bit opcode register.

The memory address comes straight from the address register. Write data comes from the memory buffer, and read data enters the memory buffer. A zero flag and a sign flag report the accumulator.

Operand buses that nothing drives read as zero. As a result, ADD alone covers three jobs: clearing a register, loading the constant 1, and copying one register to another.

Control word bits, by position:

| Bits | Group | Meaning |
|---|---|---|
| 0, 1, 2 | Operand bus A source | accumulator, program counter, address register |
| 3, 4 | Operand bus B source | memory buffer, constant 1 |
| 5 to 11 | ALU function | add, subtract, and, or, shift left, shift right, arithmetic shift right |
| 12 | Memory | read |
| 13 | Memory | write |
| 14 to 18 | Register loads | accumulator, program counter, memory buffer, address register, opcode register |

Top module: `acc_datapath`

## Requirements
- R1: After reset, all five registers read 0, so the zero flag is 1 and the sign flag is 0.
- R2: Bus A carries the accumulator (bit 0), the program counter (bit 1) or the address register (bit 2). It is 0 when none of these bits is set. An 11-bit register sits zero-extended in bus bits [10:0]. At most one of these bits may be set at a time.
- R3: Bus B carries the memory buffer (bit 3) or the constant 1 (bit 4). It is 0 when neither bit is set. At most one of these bits may be set at a time.
- R4: Add (bit 5) gives A+B and subtract (bit 6) gives A-B, both modulo 2^16. At most one function bit among 5..11 may be set.
- R5: AND (bit 7) gives A&B and OR (bit 8) gives A|B.
- R6: The shifts move bus A one place and ignore bus B. Shift left (bit 9) and logical shift right (bit 10) both fill with 0. Arithmetic shift right (bit 11) copies bit 15 into the vacated position.
- R7: With no function bit set, the result bus is 0.
- R8: The load bits (14..18) are independent and may be set together. The address register takes result[10:0] and the opcode register takes result[15:11].
- R9: A register whose load bit is clear keeps its value.
- R10: Read (bit 12) drives mem_re and loads the memory buffer from mem_rdata. A read takes precedence over a memory-buffer load from the result bus.
- R11: Write (bit 13) drives mem_we in the same cycle, with mem_addr equal to the address register and mem_wdata equal to the memory buffer. Read and write are never set together.
- R12: ac_zero is 1 exactly when the accumulator is 0. ac_neg equals accumulator bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl | input | 19 | Control word for the current cycle |
| mem_rdata | input | 16 | Data returned by memory on a read |
| mem_addr | output | 11 | Address register contents |
| mem_wdata | output | 16 | Memory buffer contents |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| ac_o | output | 16 | Accumulator |
| pc_o | output | 11 | Program counter |
| ir_o | output | 5 | Opcode register |
| ac_zero | output | 1 | Accumulator equals zero |
| ac_neg | output | 1 | Accumulator bit 15 |

## Verification
Every ALU function is tried on every pairing of a set of corner operands: 0, 1, all ones, the sign bit alone, its neighbour 0x7FFF, and alternating patterns. This separates carry and borrow wrap, sign fill against zero fill in the right shifts, and shifts that wrongly use bus B. Each source of bus A and bus B is selected on its own, and then with nothing selected. Program counter and address register values with bit 10 set show whether they are placed and zero-extended correctly. One result is loaded into four registers at once to check the split of the address and opcode fields. A read is issued together with a result-bus load of the memory buffer to show which one wins.

// File: rtl/acc_datapath.sv
module acc_datapath #(
  parameter int W  = 16,
  parameter int AW = 11,
  parameter int CW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ctl,
  input  logic [W-1:0]  mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  output logic          mem_re,
  output logic          mem_we,
  output logic [W-1:0]  ac_o,
  output logic [AW-1:0] pc_o,
  output logic [W-AW-1:0] ir_o,
  output logic          ac_zero,
  output logic          ac_neg
);
  localparam int IW = W - AW;

  logic [W-1:0]  ac, mbr, s1, s2, res;
  logic [AW-1:0] pc, mar;
  logic [IW-1:0] ir;

  wire a_ac = ctl[0], a_pc = ctl[1], a_mar = ctl[2];
  wire b_mbr = ctl[3], b_one = ctl[4];
  wire f_add = ctl[5], f_sub = ctl[6], f_and = ctl[7], f_or = ctl[8];
  wire f_shl = ctl[9], f_shr = ctl[10], f_ashr = ctl[11];
  wire m_rd = ctl[12], m_wr = ctl[13];
  wire l_ac = ctl[14], l_pc = ctl[15], l_mbr = ctl[16], l_mar = ctl[17], l_ir = ctl[18];

  assign s1 = ({W{a_ac}}  & ac)
            | ({W{a_pc}}  & {{IW{1'b0}}, pc})
            | ({W{a_mar}} & {{IW{1'b0}}, mar});

  assign s2 = ({W{b_mbr}} & mbr)
            | ({W{b_one}} & W'(1));

  assign res = ({W{f_add}}  & (s1 + s2))
             | ({W{f_sub}}  & (s1 - s2))
             | ({W{f_and}}  & (s1 & s2))
             | ({W{f_or}}   & (s1 | s2))
             | ({W{f_shl}}  & {s1[W-2:0], 1'b0})
             | ({W{f_shr}}  & {1'b0, s1[W-1:1]})
             | ({W{f_ashr}} & {s1[W-1], s1[W-1:1]});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac  <= '0;
      mbr <= '0;
      pc  <= '0;
      mar <= '0;
      ir  <= '0;
    end else begin
      if (l_ac)  ac  <= res;
      if (l_pc)  pc  <= res[AW-1:0];
      if (l_mar) mar <= res[AW-1:0];
      if (l_ir)  ir  <= res[W-1:AW];
      if (m_rd)       mbr <= mem_rdata;
      else if (l_mbr) mbr <= res;
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_re    = m_rd;
  assign mem_we    = m_wr;
  assign ac_o      = ac;
  assign pc_o      = pc;
  assign ir_o      = ir;
  assign ac_zero   = (ac == '0);
  assign ac_neg    = ac[W-1];
endmodule

// File: rtl/acc_datapath_chk.sv
module acc_datapath_chk #(
  parameter int W  = 16,
  parameter int AW = 11,
  parameter int CW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] ctl,
  input logic [W-1:0]  mem_rdata,
  input logic [AW-1:0] mem_addr,
  input logic [W-1:0]  mem_wdata,
  input logic [W-1:0]  ac_o,
  input logic [AW-1:0] pc_o,
  input logic [W-AW-1:0] ir_o,
  input logic [W-1:0]  res
);
  assert_one_s1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl[2:0]));
  assert_one_s2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl[4:3]));
  assert_one_func_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl[11:5]));
  assert_rd_wr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl[13:12]));
  assert_field_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[17] && ctl[18]) |=> ({ir_o, mem_addr} == $past(res)));
  assert_ac_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[14] |=> $stable(ac_o));
  assert_pc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[15] |=> $stable(pc_o));
  assert_read_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[12] |=> (mem_wdata == $past(mem_rdata)));
endmodule

bind acc_datapath acc_datapath_chk #(.W(W), .AW(AW), .CW(CW)) u_chk (.*);

// File: tb/test_acc_datapath.sv
module test_acc_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] ctl = '0;
  logic [15:0] mem_rdata = '0;
  logic [10:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_re, mem_we;
  logic [15:0] ac_o;
  logic [10:0] pc_o;
  logic [4:0]  ir_o;
  logic        ac_zero, ac_neg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam int A_AC = 0, A_PC = 1, A_MAR = 2, B_MBR = 3, B_ONE = 4;
  localparam int F0 = 5;
  localparam int RD = 12, WR = 13;
  localparam int L_AC = 14, L_PC = 15, L_MBR = 16, L_MAR = 17, L_IR = 18;

  always #5 clk = ~clk;

  acc_datapath i_acc_datapath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_we(mem_we),
    .ac_o(ac_o), .pc_o(pc_o), .ir_o(ir_o), .ac_zero(ac_zero), .ac_neg(ac_neg)
  );

  function automatic logic [18:0] bits(input int a, input int b = -1, input int c = -1,
                                       input int d = -1, input int e = -1);
    logic [18:0] v = '0;
    if (a >= 0) v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    if (c >= 0) v[c] = 1'b1;
    if (d >= 0) v[d] = 1'b1;
    if (e >= 0) v[e] = 1'b1;
    return v;
  endfunction

  function automatic logic [15:0] model(input int f, input logic [15:0] a, input logic [15:0] b);
    case (f)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return {a[14:0], 1'b0};
      5: return {1'b0, a[15:1]};
      6: return {a[15], a[15:1]};
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [18:0] c, input logic [15:0] d = 16'h0);
    ctl = c;
    mem_rdata = d;
    @(negedge clk);
    ctl = '0;
  endtask

  task automatic set_ac(input logic [15:0] v);
    cyc(bits(RD), v);
    cyc(bits(B_MBR, F0, L_AC));
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000,
                             16'h7FFF, 16'hAAAA, 16'h5555, 16'h1234};
    repeat (3) @(negedge clk);
    check("R1 ac", ac_o, 0);
    check("R1 mbr", mem_wdata, 0);
    check("R1 pc", pc_o, 0);
    check("R1 mar", mem_addr, 0);
    check("R1 ir", ir_o, 0);
    check("R1 R12 flags", {ac_zero, ac_neg}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5 R6 R12: all functions over all operand pairs
    for (int f = 0; f < 7; f++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          logic [15:0] e;
          set_ac(vals[i]);
          cyc(bits(RD), vals[j]);
          cyc(bits(A_AC, B_MBR, F0 + f, L_AC));
          e = model(f, vals[i], vals[j]);
          check(f < 2 ? "R4" : (f < 4 ? "R5" : "R6"), ac_o, e);
          check("R12", {ac_zero, ac_neg}, {e == 0, e[15]});
        end

    // R3 constant one, and zero bus B
    set_ac(16'hFFFF);
    cyc(bits(A_AC, B_ONE, F0, L_AC));
    check("R3 one", ac_o, 16'h0000);
    set_ac(16'h1234);
    cyc(bits(A_AC, F0, L_AC));
    check("R3 empty B", ac_o, 16'h1234);
    // R2 empty A
    cyc(bits(RD), 16'h0F0F);
    cyc(bits(B_MBR, F0 + 1, L_AC));
    check("R2 empty A", ac_o, 16'hF0F1);
    // R2 pc and mar zero-extended
    cyc(bits(RD), 16'hFFFF);
    cyc(bits(B_MBR, F0, L_PC));
    check("R2 pc load", pc_o, 11'h7FF);
    cyc(bits(A_PC, F0, L_AC));
    check("R2 pc on A", ac_o, 16'h07FF);
    cyc(bits(RD), 16'hFC05);
    cyc(bits(B_MBR, F0, L_MAR));
    cyc(bits(A_MAR, B_ONE, F0, L_AC));
    check("R2 mar on A", ac_o, 16'h0406);
    // R7 no function
    set_ac(16'hBEEF);
    cyc(bits(A_AC, B_MBR, L_AC));
    check("R7", ac_o, 16'h0000);
    // R8 multiple loads
    cyc(bits(RD), 16'hABCD);
    cyc(bits(B_MBR, F0, L_MAR, L_IR, L_PC) | bits(L_AC));
    check("R8 mar", mem_addr, 11'h3CD);
    check("R8 ir", ir_o, 5'h15);
    check("R8 pc", pc_o, 11'h3CD);
    check("R8 ac", ac_o, 16'hABCD);
    // R9 nothing loaded
    cyc(bits(A_AC, B_ONE, F0 + 1));
    check("R9 ac", ac_o, 16'hABCD);
    check("R9 pc", pc_o, 11'h3CD);
    check("R9 mar", mem_addr, 11'h3CD);
    check("R9 ir", ir_o, 5'h15);
    check("R9 mbr", mem_wdata, 16'hABCD);
    // R10 read beats result load
    cyc(bits(A_AC, F0, L_MBR, RD), 16'h1357);
    check("R10 read wins", mem_wdata, 16'h1357);
    cyc(bits(A_AC, F0, L_MBR));
    check("R10 result load", mem_wdata, 16'hABCD);
    // R10 R11 strobes
    ctl = bits(WR);
    #1;
    check("R11 we", {mem_we, mem_re}, 2'b10);
    check("R11 addr", mem_addr, 11'h3CD);
    check("R11 data", mem_wdata, 16'hABCD);
    ctl = bits(RD);
    #1;
    check("R10 re", {mem_we, mem_re}, 2'b01);
    ctl = '0;
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule